// File: doc/BRIEF.md
# TFT Panel Sync and Fetch-Address Generator

This block drives the timing side of a parallel RGB TFT panel from one internal clock. It divides that clock into a pixel clock of programmable period and phase. It then steps a horizontal position counter once per pixel period and a vertical position counter once per line. From these two counters it decodes horizontal sync, vertical sync, data enable, chip select and a data-drive window. The data-drive window places the moment pixel data is presented a programmable number of cycles before and after the active pixel clock edge.

Alongside the panel timing, the block keeps a line pointer into a frame buffer and issues one fetch strobe with an address for every visible pixel. The pointer is reloaded from a frame-base input either once per frame or on every line, and it grows by a byte stride after each visible line. The pixel address steps by one or two bytes per pixel. All timing values are pins that are held steady while the block runs. The one exception is the frame base, which is sampled each time the pointer reloads.

Top module: `tft_timing_gen`

## Requirements
- R1: Each line is, in order, `h_sync` sync periods, `h_back` back-porch periods, `h_active` visible periods and `h_front` front-porch periods, each period being one pixel clock. Each frame has the same order in lines, using the `v_*` inputs. Horizontal sync is asserted during the horizontal sync part. Vertical sync is asserted for every cycle of the vertical sync lines.
- R2: One pixel clock period lasts `clk_period` internal cycles. Inside a period, with phase 0 at its first cycle, the logical pixel clock is inactive for phases below `clk_start` and active from `clk_start` to the end. The active edge therefore falls at phase `clk_start`.
- R3: `drive_o` is high for phases from `clk_start - data_setup` up to but not including `clk_start + data_hold`, and only while data enable is logically asserted.
- R4: Data enable is logically asserted for the whole of a pixel period exactly when both the horizontal and the vertical position are in their visible parts.
- R5: Each of chip select, pixel clock, data enable, horizontal sync and vertical sync has its own polarity input: 1 drives the pin high when asserted, 0 drives it low when asserted.
- R6: Chip select is logically asserted for every cycle of the vertically visible lines and deasserted elsewhere.
- R7: `h_pix` and `v_line` give the pixel index within the visible line and the line index within the visible frame, both counted from 0. Both read 0 outside the visible region.
- R8: `fetch_valid` is high for one cycle, at phase 0, of every visible pixel period. `fetch_addr` then equals the line pointer plus `h_pix` times the increment, which is 2 when `wide_pixel` is 1 and 1 when it is 0.
- R9: After each visible line the 12-bit `line_stride` is added to the line pointer. Lines outside the visible part add nothing.
- R10: With `reload_on_hsync` at 0, the line pointer takes `frame_base` at the first cycle of every frame. With it at 1, this happens at the first cycle of every line. A reload has priority over the stride addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_active | input | HW | Visible pixels per line |
| h_front | input | HW | Horizontal front porch, pixel periods |
| h_back | input | HW | Horizontal back porch, pixel periods |
| h_sync | input | HW | Horizontal sync width, pixel periods |
| v_active | input | VW | Visible lines per frame |
| v_front | input | VW | Vertical front porch, lines |
| v_back | input | VW | Vertical back porch, lines |
| v_sync | input | VW | Vertical sync width, lines |
| clk_period | input | DW | Pixel clock period in internal cycles |
| clk_start | input | DW | Phase of the active pixel clock edge |
| data_setup | input | DW | Drive cycles before the active edge |
| data_hold | input | DW | Drive cycles from the active edge on |
| pol_cs | input | 1 | Chip select polarity, 1 = active high |
| pol_pclk | input | 1 | Pixel clock polarity |
| pol_de | input | 1 | Data enable polarity |
| pol_hs | input | 1 | Horizontal sync polarity |
| pol_vs | input | 1 | Vertical sync polarity |
| reload_on_hsync | input | 1 | 1 = reload pointer every line, 0 = every frame |
| wide_pixel | input | 1 | 1 = two bytes per pixel, 0 = one |
| frame_base | input | AW | Frame buffer base address |
| line_stride | input | SW | Bytes added after each visible line |
| pclk_o | output | 1 | Pixel clock pin |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data enable pin |
| cs_o | output | 1 | Chip select pin |
| drive_o | output | 1 | Pixel data drive window, active high |
| fetch_valid | output | 1 | Pixel fetch strobe |
| fetch_addr | output | AW | Pixel fetch address |
| h_pix | output | HW | Pixel index within visible line |
| v_line | output | VW | Line index within visible frame |

## Verification
The bound checker watches properties that must hold on every cycle:
- data enable never overlaps either sync;
- the fetch strobe and the drive window occur only under data enable;
- the fetch strobe is a single-cycle pulse;
- the horizontal position, data enable and vertical sync change only on pixel-period or line boundaries;
- the horizontal position stays below the line length.

Only the bench's scenarios can show the rest, because that needs knowledge of the programmed values over a whole frame:
- the exact frame length and the sync and enable cycle counts for several timing sets;
- the pixel clock and drive-window phases;
- the polarity mapping;
- the address sequence, including the stride after visible lines only and both reload modes.

// File: rtl/tft_timing_gen.sv
module tft_timing_gen #(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int DW = 8,
  parameter int AW = 24,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_active,
  input  logic [HW-1:0] h_front,
  input  logic [HW-1:0] h_back,
  input  logic [HW-1:0] h_sync,
  input  logic [VW-1:0] v_active,
  input  logic [VW-1:0] v_front,
  input  logic [VW-1:0] v_back,
  input  logic [VW-1:0] v_sync,
  input  logic [DW-1:0] clk_period,
  input  logic [DW-1:0] clk_start,
  input  logic [DW-1:0] data_setup,
  input  logic [DW-1:0] data_hold,
  input  logic          pol_cs,
  input  logic          pol_pclk,
  input  logic          pol_de,
  input  logic          pol_hs,
  input  logic          pol_vs,
  input  logic          reload_on_hsync,
  input  logic          wide_pixel,
  input  logic [AW-1:0] frame_base,
  input  logic [SW-1:0] line_stride,
  output logic          pclk_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          cs_o,
  output logic          drive_o,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  output logic [HW-1:0] h_pix,
  output logic [VW-1:0] v_line
);
  localparam int HCW = HW + 2;
  localparam int VCW = VW + 2;
  localparam int PW  = DW + 1;

  logic [DW-1:0]  dcnt;
  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic [AW-1:0]  line_ptr;

  wire [DW-1:0]  dlast  = (clk_period == '0) ? '0 : clk_period - 1'b1;
  wire           tick   = dcnt >= dlast;

  wire [HCW-1:0] hstart = HCW'(h_sync) + HCW'(h_back);
  wire [HCW-1:0] hend   = hstart + HCW'(h_active);
  wire [HCW-1:0] htot   = hend + HCW'(h_front);
  wire [VCW-1:0] vstart = VCW'(v_sync) + VCW'(v_back);
  wire [VCW-1:0] vend   = vstart + VCW'(v_active);
  wire [VCW-1:0] vtot   = vend + VCW'(v_front);

  wire line_end   = tick && (hcnt >= htot - 1'b1);
  wire line_start = (dcnt == '0) && (hcnt == '0);

  wire hs_l = hcnt < HCW'(h_sync);
  wire vs_l = vcnt < VCW'(v_sync);
  wire h_in = (hcnt >= hstart) && (hcnt < hend);
  wire v_in = (vcnt >= vstart) && (vcnt < vend);
  wire de_l = h_in && v_in;
  wire pc_l = dcnt >= clk_start;

  wire win_lo   = (PW'(dcnt) + PW'(data_setup)) >= PW'(clk_start);
  wire win_hi   = PW'(dcnt) < (PW'(clk_start) + PW'(data_hold));
  wire drive_l  = de_l && win_lo && win_hi;
  wire reload   = line_start && (reload_on_hsync || (vcnt == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0;
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (line_end) begin
        hcnt <= '0;
        vcnt <= (vcnt >= vtot - 1'b1) ? '0 : vcnt + 1'b1;
      end else if (tick) begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      line_ptr <= '0;
    else if (reload)
      line_ptr <= frame_base;
    else if (line_end && v_in)
      line_ptr <= line_ptr + AW'(line_stride);
  end

  assign h_pix       = h_in ? HW'(hcnt - hstart) : '0;
  assign v_line      = v_in ? VW'(vcnt - vstart) : '0;
  assign fetch_valid = de_l && (dcnt == '0);
  assign fetch_addr  = line_ptr + (wide_pixel ? (AW'(h_pix) << 1) : AW'(h_pix));
  assign drive_o     = drive_l;

  assign pclk_o  = ~(pc_l ^ pol_pclk);
  assign hsync_o = ~(hs_l ^ pol_hs);
  assign vsync_o = ~(vs_l ^ pol_vs);
  assign de_o    = ~(de_l ^ pol_de);
  assign cs_o    = ~(v_in ^ pol_cs);
endmodule

// File: rtl/tft_timing_gen_chk.sv
module tft_timing_gen_chk #(
  parameter int HCW = 14,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           line_end,
  input logic           de_l,
  input logic           hs_l,
  input logic           vs_l,
  input logic           drive_l,
  input logic           fetch_valid,
  input logic [HCW-1:0] hcnt,
  input logic [HCW-1:0] htot,
  input logic [DW-1:0]  dlast
);
  a_r4_de_clear_of_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de_l |-> (!hs_l && !vs_l));
  a_r8_fetch_under_de: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> de_l);
  a_r3_drive_under_de: assert property (@(posedge clk) disable iff (!rst_n)
    drive_l |-> de_l);
  a_r8_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && dlast != '0) |=> !fetch_valid);
  a_r1_hpos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt < htot);
  a_r1_hpos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(hcnt));
  a_r4_de_per_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(de_l));
  a_r1_vsync_per_line: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vs_l));
endmodule

bind tft_timing_gen tft_timing_gen_chk #(.HCW(HCW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .line_end(line_end),
  .de_l(de_l), .hs_l(hs_l), .vs_l(vs_l), .drive_l(drive_l),
  .fetch_valid(fetch_valid), .hcnt(hcnt), .htot(htot), .dlast(dlast)
);

// File: tb/sim_tft_timing_gen.sv
module sim_tft_timing_gen;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [11:0] h_active, h_front, h_back, h_sync;
  logic [11:0] v_active, v_front, v_back, v_sync;
  logic [7:0]  clk_period, clk_start, data_setup, data_hold;
  logic pol_cs = 0, pol_pclk = 0, pol_de = 0, pol_hs = 0, pol_vs = 0;
  logic reload_on_hsync = 0, wide_pixel = 1;
  logic [23:0] frame_base = 24'h001000;
  logic [11:0] line_stride = 12'h040;
  logic pclk_o, hsync_o, vsync_o, de_o, cs_o, drive_o, fetch_valid;
  logic [23:0] fetch_addr;
  logic [11:0] h_pix, v_line;

  tft_timing_gen u0 (
    .clk(clk), .rst_n(rst_n),
    .h_active(h_active), .h_front(h_front), .h_back(h_back), .h_sync(h_sync),
    .v_active(v_active), .v_front(v_front), .v_back(v_back), .v_sync(v_sync),
    .clk_period(clk_period), .clk_start(clk_start),
    .data_setup(data_setup), .data_hold(data_hold),
    .pol_cs(pol_cs), .pol_pclk(pol_pclk), .pol_de(pol_de), .pol_hs(pol_hs), .pol_vs(pol_vs),
    .reload_on_hsync(reload_on_hsync), .wide_pixel(wide_pixel),
    .frame_base(frame_base), .line_stride(line_stride),
    .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .cs_o(cs_o),
    .drive_o(drive_o), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .h_pix(h_pix), .v_line(v_line)
  );

  // hact hfp hbp hsw vact vfp vbp vsw period start | frame de hs vs
  localparam int VEC [3][14] = '{
    '{4, 1, 2, 1, 3, 1, 1, 1, 3, 1, 144, 36, 18, 24},
    '{2, 2, 1, 3, 2, 1, 1, 2, 2, 1,  96,  8, 36, 32},
    '{3, 1, 1, 1, 2, 1, 2, 1, 1, 0,  36,  6,  6,  6}
  };

  int checks = 0;
  int errors = 0;
  int t = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int r);
    h_active = 12'(VEC[r][0]); h_front = 12'(VEC[r][1]);
    h_back = 12'(VEC[r][2]);   h_sync = 12'(VEC[r][3]);
    v_active = 12'(VEC[r][4]); v_front = 12'(VEC[r][5]);
    v_back = 12'(VEC[r][6]);   v_sync = 12'(VEC[r][7]);
    clk_period = 8'(VEC[r][8]); clk_start = 8'(VEC[r][9]);
    data_setup = 8'd1; data_hold = 8'd1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t = 0;
  endtask

  task automatic go_to(input int n);
    while (t < n) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int r = 0; r < 3; r++) begin
      int de_c, hs_c, vs_c, fv_c;
      logic prev_vs;
      set_cfg(r);
      do_reset();
      de_c = 0; hs_c = 0; vs_c = 0; fv_c = 0; prev_vs = 1'b0;
      for (int i = 0; i < VEC[r][10]; i++) begin
        if (!de_o) de_c++;
        if (!hsync_o) hs_c++;
        if (!vsync_o) vs_c++;
        if (fetch_valid) fv_c++;
        prev_vs = ~vsync_o;
        @(negedge clk);
      end
      chk("R1 frame restarts with vsync", {62'd0, prev_vs, ~vsync_o}, 64'd1);
      chk("R4 de cycles per frame", 64'(de_c), 64'(VEC[r][11]));
      chk("R1 hsync cycles per frame", 64'(hs_c), 64'(VEC[r][12]));
      chk("R1 vsync cycles per frame", 64'(vs_c), 64'(VEC[r][13]));
      chk("R8 fetch strobes per frame", 64'(fv_c), 64'(VEC[r][11] / VEC[r][8]));
    end

    set_cfg(0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset hsync", 64'(hsync_o), 64'd0);
    chk("R1 reset vsync", 64'(vsync_o), 64'd0);
    chk("R4 reset de", 64'(de_o), 64'd1);
    chk("R6 reset cs", 64'(cs_o), 64'd1);
    chk("R8 reset fetch_valid", 64'(fetch_valid), 64'd0);
    chk("R7 reset counters", {40'd0, h_pix, v_line}, 64'd0);
    pol_cs = 1; pol_pclk = 1; pol_de = 1; pol_hs = 1; pol_vs = 1;
    #1;
    chk("R5 high polarity pins", {59'd0, pclk_o, hsync_o, vsync_o, de_o, cs_o}, 64'b01100);
    pol_cs = 0; pol_pclk = 0; pol_de = 0; pol_hs = 0; pol_vs = 0;
    #1;
    chk("R5 low polarity pins", {59'd0, pclk_o, hsync_o, vsync_o, de_o, cs_o}, 64'b10011);

    do_reset();
    go_to(48);
    chk("R6 cs on first visible line", 64'(cs_o), 64'd0);
    go_to(57);
    chk("R8 first fetch strobe", 64'(fetch_valid), 64'd1);
    chk("R8 first address", 64'(fetch_addr), 64'h1000);
    chk("R9 no stride on blank lines", 64'(fetch_addr), 64'h1000);
    chk("R7 first visible position", {40'd0, h_pix, v_line}, 64'd0);
    chk("R4 de at first pixel", 64'(de_o), 64'd0);
    chk("R3 drive at setup phase", 64'(drive_o), 64'd1);
    chk("R2 pclk before start", 64'(pclk_o), 64'd1);
    go_to(58);
    chk("R3 drive at edge phase", 64'(drive_o), 64'd1);
    chk("R2 pclk at start", 64'(pclk_o), 64'd0);
    chk("R8 strobe one cycle", 64'(fetch_valid), 64'd0);
    go_to(59);
    chk("R3 drive ends after hold", 64'(drive_o), 64'd0);
    chk("R2 pclk active to period end", 64'(pclk_o), 64'd0);
    go_to(60);
    chk("R8 wide increment", 64'(fetch_addr), 64'h1002);
    chk("R7 second pixel index", 64'(h_pix), 64'd1);
    frame_base = 24'h002000;
    go_to(81);
    chk("R9 stride after visible line", 64'(fetch_addr), 64'h1040);
    chk("R7 second visible line", 64'(v_line), 64'd1);
    go_to(90);
    chk("R8 last pixel address", 64'(fetch_addr), 64'h1046);
    go_to(93);
    chk("R4 de off in front porch", 64'(de_o), 64'd1);
    chk("R7 h_pix zero outside", 64'(h_pix), 64'd0);
    go_to(201);
    chk("R10 frame reload of new base", 64'(fetch_addr), 64'h2000);
    chk("R7 line index restarts", 64'(v_line), 64'd0);

    wide_pixel = 0;
    reload_on_hsync = 1;
    frame_base = 24'h003000;
    do_reset();
    go_to(60);
    chk("R8 narrow increment", 64'(fetch_addr), 64'h3001);
    frame_base = 24'h003800;
    go_to(81);
    chk("R10 line reload beats stride", 64'(fetch_addr), 64'h3800);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule